// File: doc/BRIEF.md
# Two-Wire Bit-Serial Bus Master

This block is the master side of a two-wire serial link. It drives a clock line and a data line that can be turned around. The caller starts a send with a parallel command word and a bit count. The master shifts out a start bit, then that many payload bits, most significant first. The caller starts a receive with a bit count. The master issues that many clock periods, samples the slave's replies and returns them as a parallel word. Data on the wire is active-low in both directions. The master inverts bits on the way out and on the way in.

The parameter `DIV` sets the length of each clock phase in system clocks. A wire clock period is a low phase followed by a high phase, and the line clock rests high between transfers. The master changes outgoing data as the clock falls, so the slave can capture it on the rising edge. Incoming data is sampled in the last system clock of the high phase, just before the next fall. The caller sees `busy` while a transfer runs and a one-cycle `done` pulse when it finishes.

Top module: `serial_link_master`

## Requirements
- R1: After reset the line clock is high, the data line is driven (`ldat_oe`=1) at the high level, and `busy`, `done` and `zero_err` are low.
- R2: Every send frame begins with a start bit: the data line is low during the first wire clock period, before any payload bit.
- R3: Wire data is active-low. A payload 1 appears as a low line level. A low line level sampled during a receive is stored as 1.
- R4: A send of N bits puts bit N-1 of `tx_word` on the wire first, then the lower bits in descending order. Exactly N+1 rising edges occur (start plus payload).
- R5: A receive of N bits shifts each new bit in at bit 0 of `rx_word`, moving earlier bits up. At the end, `rx_word[N-1]` holds the first bit, bits above N-1 are 0, and `rx_count` equals N.
- R6: Each wire clock period is `DIV` system clocks low followed by `DIV` system clocks high. The line clock is high whenever `busy` is low.
- R7: During a transfer, outgoing data changes only in the cycle where the line clock falls.
- R8: A receive bit is taken in the last system clock of the high phase. A slave that drives its bit some time after the rising edge is still read correctly.
- R9: A start with a bit count of 0 produces no clock activity, leaves `busy` low, raises no `done`, and pulses `zero_err` for one cycle.
- R10: The data line is released (`ldat_oe`=0) for a receive and driven for a send. The direction changes only while the line clock is high and was high in the previous cycle.
- R11: `done` is a one-cycle pulse. It comes DIV+2·DIV·(N+1) cycles after a send start and DIV+2·DIV·N cycles after a receive start. Starts that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Start a send (takes priority over rx_start) |
| tx_word | input | W | Command word, bits N-1..0 are sent |
| tx_bits | input | CW | Number of payload bits to send |
| rx_start | input | 1 | Start a receive |
| rx_bits | input | CW | Number of bits to receive |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| zero_err | output | 1 | One-cycle pulse for a zero bit count start |
| rx_word | output | W | Received bits, last bit at bit 0 |
| rx_count | output | CW | Number of bits received in the last receive |
| lclk | output | 1 | Line clock, idles high |
| ldat_o | output | 1 | Data line output level |
| ldat_oe | output | 1 | Data line output enable |
| ldat_i | input | 1 | Data line input level |

## Verification
A transfer starts at the clock edge that samples the start. After that edge there is a setup phase of DIV cycles with the line clock high. Then come 2·DIV cycles per wire period, and `done` is registered in the cycle that ends the last high phase. The bench counts falling system-clock edges from the start edge to the first `done` and compares the count with DIV+2·DIV·(periods). The slave model captures line levels on the rising line clock. In receive tests it drives the line one system clock after each rising edge, so the master gets a correct value only if it samples late in the high phase. A zero-count start is checked by confirming `zero_err` at the next falling system edge, then watching the line clock and `busy` for a further 40 cycles.

// File: rtl/serial_link_master.sv
module serial_link_master #(
  parameter int W   = 64,
  parameter int DIV = 4,
  parameter int CW  = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic [W-1:0]  tx_word,
  input  logic [CW-1:0] tx_bits,
  input  logic          rx_start,
  input  logic [CW-1:0] rx_bits,
  output logic          busy,
  output logic          done,
  output logic          zero_err,
  output logic [W-1:0]  rx_word,
  output logic [CW-1:0] rx_count,
  output logic          lclk,
  output logic          ldat_o,
  output logic          ldat_oe,
  input  logic          ldat_i
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int NW = $clog2(W + 2);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH} st_t;

  st_t           st;
  logic [PW-1:0] pcnt;
  logic [NW-1:0] nleft;
  logic [W-1:0]  sreg;
  logic          rxm, first;

  wire ph_end   = (pcnt == PW'(DIV - 1));
  wire fall_dat = first ? 1'b0 : ~sreg[W-1];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pcnt     <= '0;
      nleft    <= '0;
      sreg     <= '0;
      rxm      <= 1'b0;
      first    <= 1'b0;
      lclk     <= 1'b1;
      ldat_o   <= 1'b1;
      ldat_oe  <= 1'b1;
      done     <= 1'b0;
      zero_err <= 1'b0;
      rx_word  <= '0;
      rx_count <= '0;
    end else begin
      done     <= 1'b0;
      zero_err <= 1'b0;
      case (st)
        S_IDLE: begin
          pcnt <= '0;
          if (tx_start) begin
            if (tx_bits == '0) zero_err <= 1'b1;
            else begin
              st      <= S_SETUP;
              rxm     <= 1'b0;
              first   <= 1'b1;
              ldat_oe <= 1'b1;
              ldat_o  <= 1'b1;
              sreg    <= tx_word << (W - int'(tx_bits));
              nleft   <= NW'(tx_bits) + NW'(1);
            end
          end else if (rx_start) begin
            if (rx_bits == '0) zero_err <= 1'b1;
            else begin
              st       <= S_SETUP;
              rxm      <= 1'b1;
              first    <= 1'b0;
              ldat_oe  <= 1'b0;
              rx_word  <= '0;
              rx_count <= '0;
              nleft    <= NW'(rx_bits);
            end
          end
        end
        S_SETUP, S_HIGH: begin
          pcnt <= ph_end ? '0 : pcnt + PW'(1);
          if (ph_end) begin
            if (st == S_HIGH && rxm) begin
              rx_word  <= {rx_word[W-2:0], ~ldat_i};
              rx_count <= rx_count + CW'(1);
            end
            if (st == S_HIGH && nleft == NW'(1)) begin
              st    <= S_IDLE;
              done  <= 1'b1;
              nleft <= '0;
              if (!rxm) ldat_o <= 1'b1;
            end else begin
              if (st == S_HIGH) nleft <= nleft - NW'(1);
              st   <= S_LOW;
              lclk <= 1'b0;
              if (!rxm) begin
                ldat_o <= fall_dat;
                first  <= 1'b0;
                if (!first) sreg <= sreg << 1;
              end
            end
          end
        end
        S_LOW: begin
          pcnt <= ph_end ? '0 : pcnt + PW'(1);
          if (ph_end) begin
            st   <= S_HIGH;
            lclk <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_link_master_chk.sv
module serial_link_master_chk (
  input logic clk,
  input logic rst_n,
  input logic lclk,
  input logic ldat_o,
  input logic ldat_oe,
  input logic busy,
  input logic done,
  input logic zero_err
);
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lclk);

  p_dout_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(ldat_o)) |-> $fell(lclk));

  p_dir_while_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldat_oe) |-> (lclk && $past(lclk)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_err |-> (!busy && lclk && !done));
endmodule

bind serial_link_master serial_link_master_chk u_chk (.*);

// File: tb/sim_serial_link_master.sv
`timescale 1ns/1ps
module sim_serial_link_master;
  localparam int W = 64, DIV = 4, CW = $clog2(W + 1);

  logic clk = 0, rst_n = 0;
  logic tx_start = 0, rx_start = 0;
  logic [W-1:0] tx_word = '0;
  logic [CW-1:0] tx_bits = '0, rx_bits = '0;
  logic busy, done, zero_err, lclk, ldat_o, ldat_oe;
  logic [W-1:0] rx_word;
  logic [CW-1:0] rx_count;
  logic sdrv = 1'b1;
  wire ldat_i = ldat_oe ? ldat_o : sdrv;

  int total = 0, bad = 0;
  logic [127:0] cap;
  int ncap, nfall;
  logic [W-1:0] resp;
  int ridx;

  always #2.5 clk = ~clk;

  serial_link_master #(.W(W), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_word(tx_word),
    .tx_bits(tx_bits), .rx_start(rx_start), .rx_bits(rx_bits),
    .busy(busy), .done(done), .zero_err(zero_err), .rx_word(rx_word),
    .rx_count(rx_count), .lclk(lclk), .ldat_o(ldat_o), .ldat_oe(ldat_oe),
    .ldat_i(ldat_i));

  always @(posedge lclk) if (ldat_oe) begin cap = {cap[126:0], ldat_i}; ncap++; end
  always @(negedge lclk) begin
    nfall++;
    if (!ldat_oe && ridx >= 0) sdrv = resp[ridx];
  end
  always @(posedge lclk) if (!ldat_oe && ridx >= 0) begin
    #5;
    sdrv = ~resp[ridx];
    ridx--;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset;
    chk(lclk === 1'b1 && ldat_oe === 1'b1 && ldat_o === 1'b1, "R1 line idle", {lclk, ldat_oe, ldat_o}, 3'b111);
    chk(busy === 1'b0 && done === 1'b0 && zero_err === 1'b0, "R1 flags", {busy, done, zero_err}, 0);
  endtask

  task automatic t_send(input logic [W-1:0] w, input int n, input bit disturb);
    logic [127:0] exp;
    int cyc;
    exp = '0;
    for (int i = n - 1; i >= 0; i--) exp = {exp[126:0], ~w[i]};
    cap = '1; ncap = 0;
    @(negedge clk);
    tx_word = w; tx_bits = CW'(n); tx_start = 1;
    @(negedge clk); tx_start = 0;
    chk(busy === 1'b1, "R11 busy", busy, 1);
    if (disturb) begin
      repeat (3 * DIV) @(negedge clk);
      tx_word = ~w; tx_bits = CW'(1); tx_start = 1; rx_start = 1; rx_bits = CW'(5);
      @(negedge clk); tx_start = 0; rx_start = 0;
      chk(ldat_oe === 1'b1, "R11 ignored rx start", ldat_oe, 1);
      wait_done(cyc); cyc += 3 * DIV + 1;
    end else wait_done(cyc);
    chk(cyc == DIV + 2 * DIV * (n + 1), "R11 send done time", cyc, DIV + 2 * DIV * (n + 1));
    chk(ncap == n + 1, "R4 rising edge count", ncap, n + 1);
    chk(cap[n] === 1'b0, "R2 start bit low", cap[n], 0);
    chk((cap & ((128'd1 << n) - 1)) === exp, "R3 R4 inverted msb-first payload", cap, exp);
    @(negedge clk);
    chk(done === 1'b0 && lclk === 1'b1, "R11 done one cycle", {done, lclk}, 1);
  endtask

  task automatic t_recv(input logic [W-1:0] r, input int n);
    logic [W-1:0] exp;
    int cyc;
    exp = (n == W) ? r : (r & ((64'd1 << n) - 1));
    resp = r; ridx = n - 1;
    @(negedge clk);
    rx_bits = CW'(n); rx_start = 1;
    @(negedge clk); rx_start = 0;
    chk(ldat_oe === 1'b0 && lclk === 1'b1, "R10 released while high", {ldat_oe, lclk}, 1);
    wait_done(cyc);
    chk(cyc == DIV + 2 * DIV * n, "R11 recv done time", cyc, DIV + 2 * DIV * n);
    chk(rx_word === exp, "R5 R8 R3 received word", rx_word, exp);
    chk(rx_count == CW'(n), "R5 rx count", rx_count, n);
    ridx = -1; sdrv = 1'b1;
  endtask

  task automatic t_zero(input bit rx);
    int f0;
    f0 = nfall;
    @(negedge clk);
    if (rx) begin rx_bits = '0; rx_start = 1; end else begin tx_bits = '0; tx_start = 1; end
    @(negedge clk); tx_start = 0; rx_start = 0;
    chk(zero_err === 1'b1 && busy === 1'b0, "R9 zero count flag", {zero_err, busy}, 2'b10);
    repeat (40) begin
      @(negedge clk);
      if (busy || done || !lclk) break;
    end
    chk(nfall == f0 && lclk === 1'b1 && !busy && !done, "R9 no clocking", nfall - f0, 0);
  endtask

  task automatic t_phase;
    int lo, hi;
    lo = 0; hi = 0;
    @(negedge clk);
    tx_word = 64'h3; tx_bits = CW'(2); tx_start = 1;
    @(negedge clk); tx_start = 0;
    while (lclk) @(negedge clk);
    while (!lclk) begin lo++; @(negedge clk); end
    while (lclk) begin hi++; @(negedge clk); end
    chk(lo == DIV && hi == DIV, "R6 phase lengths", {lo[15:0], hi[15:0]}, {DIV[15:0], DIV[15:0]});
    while (busy) @(negedge clk);
    chk(ldat_oe === 1'b1, "R10 driven after send", ldat_oe, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    nfall = 0; ridx = -1; resp = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_send(64'hA5, 8, 0);
    t_send(64'h1, 1, 0);
    t_send(64'hF0F0_1234_8001_7E3C, 64, 0);
    t_send(64'h2D3, 10, 1);
    t_recv(64'h96, 8);
    t_recv(64'hDEAD_BEEF_0123_4567, 64);
    t_recv(64'h5, 3);
    t_send(64'h0, 4, 0);
    t_zero(0);
    t_zero(1);
    t_phase();
    report();
  end
endmodule